// File: doc/BRIEF.md
# Splintering Two-Array Address Translation Cache

This block caches virtual-to-physical translations in two fully associative arrays searched side by side. One array holds 4 MiB pages. Each of these entries carries one present bit for each of its four 1 MiB quarters. The other array holds ordinary 4 KiB pages. When an address hits a large entry whose quarter is marked absent, the large entry is skipped and the address is resolved by the 4 KiB array. This lets a big mapping cover a region while a few fragments inside it take separate, finer translations with their own memory types.

Every entry stores a 2-bit memory type beside its physical page number, and that type is returned with the translation. A lookup request is answered one clock later with registered outputs. Each array has its own fill port, which writes one entry per cycle into the slot chosen by a round-robin pointer for that array. A flush input empties both arrays in one cycle.

Top module: `splintering_tlb`

## Requirements
- R1: After a synchronous reset, rsp_valid, rsp_hit and rsp_miss are low, and a lookup misses, because every entry in both arrays is invalid.
- R2: A lookup issued with lk_req high in a cycle gets its response in the next cycle, and only then, with rsp_valid high.
- R3: A large-array hit requires three things: the entry is valid, its page number equals lk_va[31:22], and mask bit lk_va[21:20] is set. On such a hit the response gives rsp_pa = {ppn, lk_va[21:0]}, the stored memory type, and rsp_large = 1.
- R4: An address that fails the large test goes to the small array. A valid small entry whose page number equals lk_va[31:12] gives rsp_pa = {ppn, lk_va[11:0]}, its memory type, and rsp_large = 0. This also applies when the address lies in a large entry's absent quarter.
- R5: When both arrays match an address, the large entry is used.
- R6: When neither array matches, rsp_miss = 1, rsp_hit = 0, rsp_large = 0, rsp_pa = 0 and rsp_mtype = 00.
- R7: When several entries of one array match, the one with the lowest slot index wins.
- R8: Each array's fill pointer starts at slot 0 and moves up by one slot for each accepted fill, wrapping after the last slot. A fill overwrites whatever that slot held.
- R9: Memory types are coded as 00 uncacheable, 01 write-combining and 10 write-back. A fill carrying the reserved code 11 is stored as 00, so 11 is never returned.
- R10: A flush invalidates every entry of both arrays and returns both fill pointers to slot 0. A fill in the same cycle as a flush is dropped.
- R11: A lookup issued in the same cycle as a fill or a flush sees the array contents as they were before that clock edge.
- R12: rsp_hit and rsp_miss are never high together, and both are low whenever rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries and rewind the fill pointers |
| lk_req | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response present (one cycle after lk_req) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_large | output | 1 | Translation came from the large array |
| rsp_pa | output | PA_W | Physical address |
| rsp_mtype | output | 2 | Memory type of the translation |
| lg_fill_en | input | 1 | Write one large entry |
| lg_fill_vpn | input | VA_W-LARGE_SHIFT | Large virtual page number |
| lg_fill_ppn | input | PA_W-LARGE_SHIFT | Large physical page number |
| lg_fill_mask | input | 2**SUB_BITS | Quarter present mask, bit i covers quarter i |
| lg_fill_mtype | input | 2 | Memory type of the large entry |
| sm_fill_en | input | 1 | Write one 4 KiB entry |
| sm_fill_vpn | input | VA_W-SMALL_SHIFT | Small virtual page number |
| sm_fill_ppn | input | PA_W-SMALL_SHIFT | Small physical page number |
| sm_fill_mtype | input | 2 | Memory type of the small entry |

## Verification
Two kinds of same-cycle collision matter here. A lookup can coincide with a fill, and a flush can coincide with both a fill and a lookup. The bench drives these on one clock edge. It expects the lookup to be answered from the contents held before the edge, and it expects a fill that collides with a flush to leave no trace: the following sweep must miss everywhere, and the next fills must start again at slot 0, which shows up in which page is evicted first. Around these collisions, lookups over every quarter of six large pages, at three small pages each, are compared against an arithmetic model of both arrays.

// File: rtl/splt_pkg.sv
package splt_pkg;

  typedef enum logic [1:0] {
    MT_UC  = 2'b00,
    MT_WC  = 2'b01,
    MT_WB  = 2'b10,
    MT_RSV = 2'b11
  } mtype_e;

  // Reserved code collapses to uncacheable on the way into storage.
  function automatic logic [1:0] mt_sanitize(input logic [1:0] mt);
    return (mt == MT_RSV) ? MT_UC : mt;
  endfunction

endpackage

// File: rtl/splt_rr_ptr.sv
module splt_rr_ptr #(
  parameter int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          adv,
  output logic [PW-1:0] ptr
);

  localparam logic [PW-1:0] LAST = PW'(N - 1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/splt_large_bank.sv
module splt_large_bank #(
  parameter int ENTRIES  = 4,
  parameter int VPN_W    = 10,
  parameter int PPN_W    = 10,
  parameter int SUB_BITS = 2,
  localparam int SUBS    = 1 << SUB_BITS,
  localparam int PW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                wr_en,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [SUBS-1:0]     wr_mask,
  input  logic [1:0]          wr_mt,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [SUB_BITS-1:0] lk_sub,
  output logic                hit,
  output logic [PPN_W-1:0]    ppn,
  output logic [1:0]          mt
);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [SUBS-1:0]    mask_q [ENTRIES];
  logic [1:0]         mt_q   [ENTRIES];
  logic [PW-1:0]      victim;
  logic               do_wr;
  logic [ENTRIES-1:0] match;

  assign do_wr = wr_en && !flush;

  splt_rr_ptr #(.N(ENTRIES)) rr_i (
    .clk   (clk),
    .rst   (rst),
    .clear (flush),
    .adv   (do_wr),
    .ptr   (victim)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (do_wr) begin
      vld_q[victim] <= 1'b1;
    end
  end

  // Payload without reset so it can map onto plain storage.
  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[victim]  <= wr_vpn;
      ppn_q[victim]  <= wr_ppn;
      mask_q[victim] <= wr_mask;
      mt_q[victim]   <= wr_mt;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (vpn_q[i] == lk_vpn) && mask_q[i][lk_sub];
  end

  // Lowest matching slot wins: scan downward so low indices overwrite.
  always_comb begin
    hit = |match;
    ppn = '0;
    mt  = 2'b00;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        ppn = ppn_q[i];
        mt  = mt_q[i];
      end
    end
  end

endmodule

// File: rtl/splt_small_bank.sv
module splt_small_bank #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int PW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [1:0]       wr_mt,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output logic [1:0]       mt
);

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [1:0]         mt_q  [ENTRIES];
  logic [PW-1:0]      victim;
  logic               do_wr;
  logic [ENTRIES-1:0] match;

  assign do_wr = wr_en && !flush;

  splt_rr_ptr #(.N(ENTRIES)) rr_i (
    .clk   (clk),
    .rst   (rst),
    .clear (flush),
    .adv   (do_wr),
    .ptr   (victim)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld_q <= '0;
    end else if (do_wr) begin
      vld_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      vpn_q[victim] <= wr_vpn;
      ppn_q[victim] <= wr_ppn;
      mt_q[victim]  <= wr_mt;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld_q[i] && (vpn_q[i] == lk_vpn);
  end

  always_comb begin
    hit = |match;
    ppn = '0;
    mt  = 2'b00;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        ppn = ppn_q[i];
        mt  = mt_q[i];
      end
    end
  end

endmodule

// File: rtl/splintering_tlb.sv
module splintering_tlb
  import splt_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int LG_ENTRIES  = 4,
  parameter int SM_ENTRIES  = 8,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 22,
  parameter int SUB_BITS    = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          lk_req,
  input  logic [VA_W-1:0]               lk_va,
  output logic                          rsp_valid,
  output logic                          rsp_hit,
  output logic                          rsp_miss,
  output logic                          rsp_large,
  output logic [PA_W-1:0]               rsp_pa,
  output logic [1:0]                    rsp_mtype,
  input  logic                          lg_fill_en,
  input  logic [VA_W-LARGE_SHIFT-1:0]   lg_fill_vpn,
  input  logic [PA_W-LARGE_SHIFT-1:0]   lg_fill_ppn,
  input  logic [(1<<SUB_BITS)-1:0]      lg_fill_mask,
  input  logic [1:0]                    lg_fill_mtype,
  input  logic                          sm_fill_en,
  input  logic [VA_W-SMALL_SHIFT-1:0]   sm_fill_vpn,
  input  logic [PA_W-SMALL_SHIFT-1:0]   sm_fill_ppn,
  input  logic [1:0]                    sm_fill_mtype
);

  localparam int LVPN_W = VA_W - LARGE_SHIFT;
  localparam int LPPN_W = PA_W - LARGE_SHIFT;
  localparam int SVPN_W = VA_W - SMALL_SHIFT;
  localparam int SPPN_W = PA_W - SMALL_SHIFT;

  logic [LVPN_W-1:0]   lk_lvpn;
  logic [SUB_BITS-1:0] lk_sub;
  logic [SVPN_W-1:0]   lk_svpn;
  logic                lg_hit, sm_hit;
  logic [LPPN_W-1:0]   lg_ppn;
  logic [SPPN_W-1:0]   sm_ppn;
  logic [1:0]          lg_mt, sm_mt;

  logic                nx_hit, nx_large;
  logic [PA_W-1:0]     nx_pa;
  logic [1:0]          nx_mt;

  assign lk_lvpn = lk_va[VA_W-1:LARGE_SHIFT];
  assign lk_sub  = lk_va[LARGE_SHIFT-1 -: SUB_BITS];
  assign lk_svpn = lk_va[VA_W-1:SMALL_SHIFT];

  splt_large_bank #(
    .ENTRIES  (LG_ENTRIES),
    .VPN_W    (LVPN_W),
    .PPN_W    (LPPN_W),
    .SUB_BITS (SUB_BITS)
  ) large_i (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .wr_en   (lg_fill_en),
    .wr_vpn  (lg_fill_vpn),
    .wr_ppn  (lg_fill_ppn),
    .wr_mask (lg_fill_mask),
    .wr_mt   (mt_sanitize(lg_fill_mtype)),
    .lk_vpn  (lk_lvpn),
    .lk_sub  (lk_sub),
    .hit     (lg_hit),
    .ppn     (lg_ppn),
    .mt      (lg_mt)
  );

  splt_small_bank #(
    .ENTRIES (SM_ENTRIES),
    .VPN_W   (SVPN_W),
    .PPN_W   (SPPN_W)
  ) small_i (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .wr_en  (sm_fill_en),
    .wr_vpn (sm_fill_vpn),
    .wr_ppn (sm_fill_ppn),
    .wr_mt  (mt_sanitize(sm_fill_mtype)),
    .lk_vpn (lk_svpn),
    .hit    (sm_hit),
    .ppn    (sm_ppn),
    .mt     (sm_mt)
  );

  // A large hit already excludes absent quarters, so the small array
  // serves both plain small pages and splintered fragments.
  always_comb begin
    nx_hit   = 1'b0;
    nx_large = 1'b0;
    nx_pa    = '0;
    nx_mt    = MT_UC;
    if (lg_hit) begin
      nx_hit   = 1'b1;
      nx_large = 1'b1;
      nx_pa    = {lg_ppn, lk_va[LARGE_SHIFT-1:0]};
      nx_mt    = lg_mt;
    end else if (sm_hit) begin
      nx_hit = 1'b1;
      nx_pa  = {sm_ppn, lk_va[SMALL_SHIFT-1:0]};
      nx_mt  = sm_mt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_large <= 1'b0;
      rsp_pa    <= '0;
      rsp_mtype <= MT_UC;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_req && nx_hit;
      rsp_miss  <= lk_req && !nx_hit;
      rsp_large <= lk_req && nx_large;
      rsp_pa    <= lk_req ? nx_pa : '0;
      rsp_mtype <= lk_req ? nx_mt : MT_UC;
    end
  end

endmodule

// File: rtl/splt_tlb_chk.sv
module splt_tlb_chk #(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 22
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_va,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic            rsp_large,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_mtype
);

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> rsp_valid);

  // R2
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !rsp_valid);

  // R12
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !rsp_hit && !rsp_miss && !rsp_large);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> rsp_pa == '0 && rsp_mtype == 2'b00 && !rsp_large);

  // R9
  no_reserved_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_mtype != 2'b11);

  // R3
  large_offset_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_large |-> rsp_hit && rsp_pa[LARGE_SHIFT-1:0] == $past(lk_va[LARGE_SHIFT-1:0]));

  // R4
  small_offset_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_pa[SMALL_SHIFT-1:0] == $past(lk_va[SMALL_SHIFT-1:0]));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush ##1 lk_req |=> rsp_miss);

endmodule

bind splintering_tlb splt_tlb_chk #(
  .VA_W        (VA_W),
  .PA_W        (PA_W),
  .SMALL_SHIFT (SMALL_SHIFT),
  .LARGE_SHIFT (LARGE_SHIFT)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .lk_req    (lk_req),
  .lk_va     (lk_va),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_large (rsp_large),
  .rsp_pa    (rsp_pa),
  .rsp_mtype (rsp_mtype)
);

// File: tb/splintering_tlb_tb_top.sv
`timescale 1ns/1ps
module splintering_tlb_tb_top;

  localparam int LG = 4;
  localparam int SM = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_large;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_mtype;
  logic        lg_fill_en = 1'b0;
  logic [9:0]  lg_fill_vpn = '0, lg_fill_ppn = '0;
  logic [3:0]  lg_fill_mask = '0;
  logic [1:0]  lg_fill_mtype = '0;
  logic        sm_fill_en = 1'b0;
  logic [19:0] sm_fill_vpn = '0, sm_fill_ppn = '0;
  logic [1:0]  sm_fill_mtype = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  splintering_tlb #(.LG_ENTRIES(LG), .SM_ENTRIES(SM)) dut_i (
    .clk(clk), .rst(rst), .flush(flush), .lk_req(lk_req), .lk_va(lk_va),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_large(rsp_large), .rsp_pa(rsp_pa), .rsp_mtype(rsp_mtype),
    .lg_fill_en(lg_fill_en), .lg_fill_vpn(lg_fill_vpn), .lg_fill_ppn(lg_fill_ppn),
    .lg_fill_mask(lg_fill_mask), .lg_fill_mtype(lg_fill_mtype),
    .sm_fill_en(sm_fill_en), .sm_fill_vpn(sm_fill_vpn), .sm_fill_ppn(sm_fill_ppn),
    .sm_fill_mtype(sm_fill_mtype)
  );

  // Reference model of both arrays.
  bit          mlv [LG];
  logic [9:0]  mlvpn [LG], mlppn [LG];
  logic [3:0]  mlmask [LG];
  logic [1:0]  mlmt [LG];
  int          mlp = 0;
  bit          msv [SM];
  logic [19:0] msvpn [SM], msppn [SM];
  logic [1:0]  msmt [SM];
  int          msp = 0;

  function automatic logic [1:0] san(input logic [1:0] m);
    return (m == 2'b11) ? 2'b00 : m;
  endfunction

  function automatic logic [19:0] spage(input int vl, input int sub, input int pg);
    return {10'(vl), 2'(sub), 8'(pg)};
  endfunction

  task automatic model_look(input logic [31:0] va, output logic h, output logic l,
                            output logic [31:0] pa, output logic [1:0] mt);
    h = 1'b0; l = 1'b0; pa = '0; mt = 2'b00;
    for (int i = 0; i < LG; i++)
      if (!h && mlv[i] && mlvpn[i] == va[31:22] && mlmask[i][va[21:20]]) begin
        h = 1'b1; l = 1'b1; pa = {mlppn[i], va[21:0]}; mt = mlmt[i];
      end
    for (int i = 0; i < SM; i++)
      if (!h && msv[i] && msvpn[i] == va[31:12]) begin
        h = 1'b1; pa = {msppn[i], va[11:0]}; mt = msmt[i];
      end
  endtask

  task automatic check(input bit ok, input string req, input string info);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, info);
    end
  endtask

  task automatic step(input bit do_lk, input logic [31:0] va,
                      input bit do_lf, input int lvpn, input int lppn, input logic [3:0] lmask,
                      input logic [1:0] lmt,
                      input bit do_sf, input logic [19:0] svpn, input logic [19:0] sppn,
                      input logic [1:0] smt, input bit do_fl, input string ctx);
    logic eh, el;
    logic [31:0] ep;
    logic [1:0] em;
    string tag;
    bit ok;
    @(negedge clk);
    lk_req = do_lk; lk_va = va;
    lg_fill_en = do_lf; lg_fill_vpn = 10'(lvpn); lg_fill_ppn = 10'(lppn);
    lg_fill_mask = lmask; lg_fill_mtype = lmt;
    sm_fill_en = do_sf; sm_fill_vpn = svpn; sm_fill_ppn = sppn; sm_fill_mtype = smt;
    flush = do_fl;
    model_look(va, eh, el, ep, em);
    if (do_fl) begin
      for (int i = 0; i < LG; i++) mlv[i] = 1'b0;
      for (int i = 0; i < SM; i++) msv[i] = 1'b0;
      mlp = 0; msp = 0;
    end else begin
      if (do_lf) begin
        mlv[mlp] = 1'b1; mlvpn[mlp] = 10'(lvpn); mlppn[mlp] = 10'(lppn);
        mlmask[mlp] = lmask; mlmt[mlp] = san(lmt); mlp = (mlp + 1) % LG;
      end
      if (do_sf) begin
        msv[msp] = 1'b1; msvpn[msp] = svpn; msppn[msp] = sppn;
        msmt[msp] = san(smt); msp = (msp + 1) % SM;
      end
    end
    @(negedge clk);
    lk_req = 1'b0; lg_fill_en = 1'b0; sm_fill_en = 1'b0; flush = 1'b0;
    if (do_lk) begin
      tag = el ? "R3" : (eh ? "R4" : "R6");
      ok = rsp_valid === 1'b1 && rsp_hit === eh && rsp_miss === !eh &&
           rsp_large === el && rsp_pa === ep && rsp_mtype === em;
      check(ok, {tag, "/R2/R12 ", ctx},
            $sformatf("va=%h act v%b h%b m%b l%b pa=%h mt=%b exp h%b l%b pa=%h mt=%b",
                      va, rsp_valid, rsp_hit, rsp_miss, rsp_large, rsp_pa, rsp_mtype,
                      eh, el, ep, em));
    end
  endtask

  task automatic look(input logic [31:0] va, input string ctx);
    step(1, va, 0, 0, 0, 4'h0, 2'b00, 0, '0, '0, 2'b00, 0, ctx);
  endtask

  task automatic lfill(input int vl, input int ppn, input logic [3:0] mask, input logic [1:0] mt);
    step(0, '0, 1, vl, ppn, mask, mt, 0, '0, '0, 2'b00, 0, "fill");
  endtask

  task automatic sfill(input logic [19:0] vpn, input logic [19:0] ppn, input logic [1:0] mt);
    step(0, '0, 0, 0, 0, 4'h0, 2'b00, 1, vpn, ppn, mt, 0, "fill");
  endtask

  task automatic sweep(input string ctx);
    int pgs [3] = '{0, 1, 255};
    for (int vl = 0; vl < 6; vl++)
      for (int sub = 0; sub < 4; sub++)
        for (int k = 0; k < 3; k++)
          look({10'(vl), 2'(sub), 8'(pgs[k]), 12'((vl * 373 + sub * 91 + pgs[k] * 7) & 12'hFFF)}, ctx);
  endtask

  initial begin
    #(1_000_000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog expired act=hung exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < LG; i++) mlv[i] = 1'b0;
    for (int i = 0; i < SM; i++) msv[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: outputs quiet after reset, arrays empty.
    check(rsp_valid === 1'b0 && rsp_hit === 1'b0 && rsp_miss === 1'b0, "R1",
          $sformatf("act v%b h%b m%b exp 000", rsp_valid, rsp_hit, rsp_miss));
    look(32'h0040_1234, "R1 empty after reset");
    // R2: no response in a cycle without a request.
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2", $sformatf("idle valid act=%b exp=0", rsp_valid));

    // Phase A: masks with absent quarters, reserved type (R9), overlaps (R5).
    lfill(1, 10'h3A1, 4'b1110, 2'b10);
    lfill(2, 10'h155, 4'b0001, 2'b01);
    lfill(3, 10'h2F0, 4'b1010, 2'b11);
    lfill(4, 10'h0C7, 4'b1111, 2'b00);
    sfill(spage(1, 0, 0),   20'hABCDE, 2'b10);
    sfill(spage(1, 0, 1),   20'h12345, 2'b01);
    sfill(spage(1, 2, 0),   20'h55555, 2'b00);
    sfill(spage(2, 3, 255), 20'h0F0F0, 2'b10);
    sfill(spage(3, 0, 0),   20'h11111, 2'b11);
    sfill(spage(5, 1, 1),   20'h22222, 2'b01);
    sfill(spage(0, 0, 0),   20'h33333, 2'b10);
    sfill(spage(4, 1, 255), 20'h44444, 2'b01);
    sweep("A R5 R9 splinter sweep");

    // Phase B: wraparound evicts slot 0 in both arrays (R8), duplicate vpn (R7).
    sfill(spage(5, 3, 0), 20'h66666, 2'b10);
    lfill(2, 10'h1EE, 4'b1111, 2'b10);
    sweep("B R7 R8 wrap sweep");

    // Phase C: lookup in the same cycle as fills sees old contents (R11).
    step(1, {spage(5, 2, 7), 12'h0AB}, 0, 0, 0, 4'h0, 2'b00,
         1, spage(5, 2, 7), 20'h77777, 2'b01, 0, "R11 lookup+small fill");
    look({spage(5, 2, 7), 12'h0AB}, "R11 after small fill");
    step(1, {10'd6, 2'd1, 8'd3, 12'h321}, 1, 6, 10'h0AA, 4'b0010, 2'b01,
         0, '0, '0, 2'b00, 0, "R11 lookup+large fill");
    look({10'd6, 2'd1, 8'd3, 12'h321}, "R11 after large fill");

    // Phase D: flush collides with fill and lookup (R10, R11).
    step(1, {10'd4, 2'd0, 8'd9, 12'h777}, 1, 7, 10'h3FF, 4'b1111, 2'b10,
         1, spage(6, 0, 0), 20'h88888, 2'b10, 1, "R10 R11 lookup+fill+flush");
    sweep("R10 after flush");
    look({10'd7, 2'd2, 8'd0, 12'h000}, "R10 dropped large fill");
    look({spage(6, 0, 0), 12'h010}, "R10 dropped small fill");

    // Pointer rewound to slot 0: ninth fill evicts the first one (R8).
    for (int k = 0; k < 9; k++) sfill(spage(6, 0, k), 20'(32'h9_0000 + k), 2'(k % 3));
    look({spage(6, 0, 0), 12'h044}, "R8 first evicted");
    look({spage(6, 0, 1), 12'h055}, "R8 second kept");
    look({spage(6, 0, 8), 12'h066}, "R8 newest in slot 0");
    for (int k = 0; k < 5; k++) lfill(8 + k, 10'h100 + k, 4'b1111, 2'(k % 3));
    look({10'd8, 2'd0, 8'd0, 12'h001}, "R8 large first evicted");
    look({10'd9, 2'd3, 8'd0, 12'h002}, "R8 large second kept");
    look({10'd12, 2'd1, 8'd0, 12'h003}, "R8 large newest");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule